// File: doc/BRIEF.md
# Dual-Input Handshaked FIFO

This block is a single-clock first-in first-out buffer with a parameterised word width and depth. A word can be stored from either of two write data buses. A select input chosen at push time decides which bus supplies the word. The block is meant for a datapath that has two possible producers feeding one consumer. It saves an external multiplexer in front of the buffer.

Both sides use a request/acknowledge pair. The read acknowledge is high whenever at least one word is held, and the write acknowledge is high whenever at least one slot is free. A transfer happens on a clock edge only when the request and its acknowledge are both high in that cycle. Other requests are ignored. The read bus always shows the oldest stored word, so the consumer sees the data before it pops it. The next word appears after the edge on which the pop is taken.

Occupancy is held as a separate counter beside the two pointers. Full and empty can therefore be told apart for any depth of two or more, including depths that are not powers of two.

Top module: `dualbus_fifo`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted and just after it is released, the FIFO is empty: `rdAck` is 0 and `wrAck` is 1.
- R2: On an accepted push, the word stored is `wrDataA` when `busSel` is 0 and `wrDataB` when `busSel` is 1.
- R3: `rdAck` is 1 exactly when the FIFO holds at least one word.
- R4: `wrAck` is 1 exactly when the FIFO holds fewer than DEPTH words.
- R5: A write request while `wrAck` is 0 is ignored: the occupancy and the stored words are unchanged, and `rdData` and the later read order show no trace of the refused word.
- R6: A read request while `rdAck` is 0 is ignored: nothing is popped and the occupancy stays zero unless a push is accepted in the same cycle.
- R7: While `rdAck` is 1, `rdData` shows the oldest stored word. It changes only after an edge on which a pop is accepted.
- R8: When a push and a pop are both accepted on the same edge, the occupancy is unchanged. A push into an empty FIFO is never presented on `rdData` in the same cycle: `rdAck` rises only after the edge that stores the word.
- R9: Words leave in the order they were accepted across any number of pointer wraps, including depths that are not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; empties the FIFO |
| rdReq | input | 1 | Read request; pops when `rdAck` is high |
| wrReq | input | 1 | Write request; pushes when `wrAck` is high |
| rdAck | output | 1 | High when the FIFO is not empty |
| wrAck | output | 1 | High when the FIFO is not full |
| busSel | input | 1 | Write bus select: 0 picks `wrDataA`, 1 picks `wrDataB` |
| wrDataA | input | WIDTH | First write data bus |
| wrDataB | input | WIDTH | Second write data bus |
| rdData | output | WIDTH | Oldest stored word |

## Verification
A wrong occupancy count shows up at the handshake outputs. `rdAck` or `wrAck` takes a wrong value on the edge after the bad update, or at the latest once the count reaches zero or DEPTH. A pointer that slips, or a wrong bus selection, appears on `rdData` as soon as the affected word becomes the oldest one, which can take up to DEPTH pops. The reference model is compared on every cycle, so a fault is caught at that first visible point. Traffic is run at a non-power-of-two depth so that the wrap logic is exercised.

// File: rtl/dualbus_fifo_pkg.sv
package dualbus_fifo_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic push;   // store the selected input word, advance write pointer
    logic pop;    // advance read pointer
  } fifoStrobe_t;
endpackage

// File: rtl/dualbus_fifo_ctrl.sv
module dualbus_fifo_ctrl
  import dualbus_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdReq,
  input  logic        wrReq,
  output logic        rdAck,
  output logic        wrAck,
  output fifoStrobe_t strobe
);
  localparam int CntW = $clog2(DEPTH + 1);
  localparam logic [CntW-1:0] FullCnt = CntW'(DEPTH);

  logic [CntW-1:0] count;
  logic notEmpty, notFull;

  assign notEmpty = (count != '0);
  assign notFull  = (count != FullCnt);

  assign strobe.push = wrReq & notFull;
  assign strobe.pop  = rdReq & notEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdAck = notEmpty;
  assign wrAck = notFull;
endmodule

// File: rtl/dualbus_fifo_dp.sv
module dualbus_fifo_dp
  import dualbus_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic             busSel,
  input  logic [WIDTH-1:0] wrDataA,
  input  logic [WIDTH-1:0] wrDataB,
  output logic [WIDTH-1:0] rdData
);
  localparam int PtrW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PtrW-1:0] LastIdx = PtrW'(DEPTH - 1);
  localparam bit IsPow2 = (DEPTH == (1 << PtrW));

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PtrW-1:0]  wrPtr, rdPtr, wrNext, rdNext;
  logic [WIDTH-1:0] inWord;

  // Input bus selection
  always_comb begin
    inWord = busSel ? wrDataB : wrDataA;
  end

  // Pointer advance: natural rollover for power-of-two depths,
  // explicit wrap otherwise
  generate
    if (IsPow2) begin : g_wrapFree
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrapCmp
      assign wrNext = (wrPtr == LastIdx) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == LastIdx) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrNext;
      if (strobe.pop)  rdPtr <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= inWord;
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/dualbus_fifo.sv
module dualbus_fifo
  import dualbus_fifo_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReq,
  input  logic             wrReq,
  output logic             rdAck,
  output logic             wrAck,
  input  logic             busSel,
  input  logic [WIDTH-1:0] wrDataA,
  input  logic [WIDTH-1:0] wrDataB,
  output logic [WIDTH-1:0] rdData
);
  fifoStrobe_t strobe;

  dualbus_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdReq  (rdReq),
    .wrReq  (wrReq),
    .rdAck  (rdAck),
    .wrAck  (wrAck),
    .strobe (strobe)
  );

  dualbus_fifo_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busSel  (busSel),
    .wrDataA (wrDataA),
    .wrDataB (wrDataB),
    .rdData  (rdData)
  );
endmodule

// File: rtl/dualbus_fifo_chk.sv
module dualbus_fifo_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdReq,
  input logic             wrReq,
  input logic             rdAck,
  input logic             wrAck,
  input logic [WIDTH-1:0] rdData
);
  // R1: empty while reset is held
  always @(posedge clk) begin
    if (!rstN) a_r1_reset_empty: assert (!rdAck && wrAck);
  end

  // R3/R4: the FIFO can never be both empty and full
  a_r3_empty_not_full: assert property (@(posedge clk) disable iff (!rstN)
    !rdAck |-> wrAck);
  a_r4_full_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    !wrAck |-> rdAck);

  // R5: refused push with no pop keeps the FIFO full
  a_r5_full_push_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck && !rdReq) |=> !wrAck);

  // R6: read of an empty FIFO with no push keeps it empty
  a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck && !wrReq) |=> !rdAck);

  // R7: head word holds while nothing is popped
  a_r7_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && !rdReq) |=> (rdAck && $stable(rdData)));

  // R8: push into empty shows up one edge later, never earlier
  a_r8_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (!rdAck && wrReq) |=> rdAck);

  // R8: accepted push and pop together leave the flags unchanged
  a_r8_simul_keeps_level: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && wrReq && wrAck) |=> ($stable(rdAck) && $stable(wrAck)));
endmodule

bind dualbus_fifo dualbus_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdReq  (rdReq),
  .wrReq  (wrReq),
  .rdAck  (rdAck),
  .wrAck  (wrAck),
  .rdData (rdData)
);

// File: tb/dualbus_fifo_bench.sv
`timescale 1ns/1ps
module dualbus_fifo_bench;
  localparam int W = 32;
  localparam int D = 5;   // non-power-of-two depth exercises the wrap logic

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rdReq = 1'b0, wrReq = 1'b0, busSel = 1'b0;
  logic [W-1:0] wrDataA = '0, wrDataB = '0;
  logic         rdAck, wrAck;
  logic [W-1:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  logic [W-1:0] model [$];

  always #10 clk = ~clk;   // 50 MHz

  dualbus_fifo #(.WIDTH(W), .DEPTH(D)) u_dualbus_fifo (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq),
    .rdAck(rdAck), .wrAck(wrAck), .busSel(busSel),
    .wrDataA(wrDataA), .wrDataB(wrDataB), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: a queue limited to D entries
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      model.delete();
    end else begin
      logic [W-1:0] w;
      bit doPop, doPush;
      w      = busSel ? wrDataB : wrDataA;
      doPop  = rdReq && (model.size() > 0);
      doPush = wrReq && (model.size() < D);
      if (doPop)  void'(model.pop_front());
      if (doPush) model.push_back(w);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live) begin
      check("R3 rdAck", W'(rdAck), W'(model.size() > 0));
      check("R4 wrAck", W'(wrAck), W'(model.size() < D));
      if (model.size() > 0) check("R7 rdData head", rdData, model[0]);
    end
  end

  task automatic drive(input bit rd, input bit wr, input bit sel,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    rdReq = rd; wrReq = wr; busSel = sel; wrDataA = a; wrDataB = b;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdAck in reset", W'(rdAck), W'(0));
    check("R1 wrAck in reset", W'(wrAck), W'(1));
    rstN = 1'b1;
    live = 1'b1;
    @(negedge clk);
    check("R1 rdAck after reset", W'(rdAck), W'(0));
    check("R1 wrAck after reset", W'(wrAck), W'(1));

    // R6: read from empty is ignored
    drive(1, 0, 0, '0, '0);
    drive(0, 0, 0, '0, '0);
    @(negedge clk);
    check("R6 empty read ignored", W'(rdAck), W'(0));

    // R2 / R8: push from bus B into empty, no same-cycle bypass
    drive(1, 1, 1, 32'hAAAA_0001, 32'hBBBB_0001);
    #1; check("R8 no bypass before edge", W'(rdAck), W'(0));
    drive(0, 0, 0, '0, '0);
    #1; check("R2 bus B stored", rdData, 32'hBBBB_0001);
    // R2: bus A selected
    drive(0, 1, 0, 32'hAAAA_0002, 32'hBBBB_0002);
    drive(1, 0, 0, '0, '0);
    drive(0, 0, 0, '0, '0);
    #1; check("R2 bus A stored", rdData, 32'hAAAA_0002);
    drive(1, 0, 0, '0, '0);
    drive(0, 0, 0, '0, '0);

    // R5: fill, push while full, drain and verify order
    for (int i = 0; i < D; i++) drive(0, 1, i[0], 32'h1000 + i, 32'h2000 + i);
    drive(0, 1, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    drive(0, 0, 0, '0, '0);
    #1;
    check("R5 still full", W'(wrAck), W'(0));
    check("R5 head unchanged", rdData, 32'h1000);
    // R8: simultaneous push and pop while full: pop accepted, push refused
    drive(1, 1, 0, 32'h3000, 32'h3000);
    drive(0, 0, 0, '0, '0);
    #1; check("R8 full rd+wr frees one slot", W'(wrAck), W'(1));
    // R8: simultaneous push and pop at mid level
    drive(1, 1, 1, 32'h4000, 32'h4001);
    drive(0, 0, 0, '0, '0);
    #1; check("R8 level kept", W'(wrAck), W'(1));
    for (int i = 0; i < D; i++) drive(1, 0, 0, '0, '0);
    drive(0, 0, 0, '0, '0);
    #1; check("R9 drained", W'(rdAck), W'(0));

    // R9: random traffic across many wraps, model compared every cycle
    for (int i = 0; i < 3000; i++)
      drive(1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
    drive(0, 0, 0, '0, '0);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule